// File: doc/BRIEF.md
# Fault-Injectable Bit RAM

This block is a synchronous RAM of 2^AW one-bit cells. A fault injector is built into it. It serves as the device under test when a March-style self-test engine or a testbench is developed. With injection switched off it behaves as an ideal RAM: writes land in the addressed cell, and a read returns the stored bit one clock later.

With injection switched on, a small set of static inputs selects the fault:

- one fault kind;
- a victim cell;
- an aggressor cell;
- a forced or blocked value (`flt_val`);
- an aggressor trigger value (`flt_trig`).

The kinds cover the classic functional memory faults. These are cells that stick, cells that cannot make one transition, and cells coupled to a neighbour by a transition or by a level. The other kinds are shorted cell pairs, two addresses that have traded places in the decoder, and a cell that cannot be addressed at all.

Reads and writes pass through the same address decode, so an injected fault looks the same to both. A coupling fault is sensitized only by a write that really changes the aggressor's stored bit. An unreachable cell returns one bit of a free-running LFSR, so that runs can be repeated exactly.

Top module: `fault_ram`

## Requirements
- R1: After reset every cell holds 0 and `rdata` is 0.
- R2: When `flt_on` is 0, whatever `flt_kind` holds, a write stores `wdata` in cell `addr`, and a read of `addr` presents the stored bit on `rdata` after the next rising edge.
- R3: Kind 1 (stuck): the victim cell holds `flt_val` and returns it on every read. Writes to the victim have no effect. Other cells work normally.
- R4: Kind 2 (transition): a write that would change the victim to `flt_val` is blocked, and the victim keeps its old bit. The opposite change and same-value writes work.
- R5: Kind 3 (inversion coupling): a write that changes the aggressor's stored bit to `flt_trig` inverts the victim. Rewriting the same value, or changing the aggressor the other way, leaves the victim unchanged.
- R6: Kind 4 (idempotent coupling): a write that changes the aggressor's stored bit to `flt_trig` sets the victim to `flt_val`. Otherwise the victim stays writable.
- R7: Kind 5 (state coupling): while the aggressor stores `flt_trig`, the victim is held at `flt_val` and writes to it are lost. Once the aggressor changes, the victim keeps its value and can be written again.
- R8: Kinds 6 and 7 (bridging): a read of the victim or of the aggressor returns the AND (kind 6) or the OR (kind 7) of the two stored bits. Stored contents are not altered.
- R9: Kind 8 (decoder swap): accesses to the victim address reach the aggressor cell and vice versa. This shows when injection is later turned off.
- R10: Kind 9 (unreachable cell): writes to the victim address are lost. Reads of it return a bit from a nonzero free-running LFSR, which yields both 0 and 1 over repeated reads.
- R11: `rdata` changes only on a clock edge where `rd_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flt_on | input | 1 | Fault injection enable |
| flt_kind | input | 4 | Fault kind: 0 none, 1 stuck, 2 transition, 3 inversion coupling, 4 idempotent coupling, 5 state coupling, 6 AND bridge, 7 OR bridge, 8 decoder swap, 9 unreachable; 10 to 15 act as none |
| flt_victim | input | AW | Victim cell address |
| flt_aggr | input | AW | Aggressor cell address |
| flt_val | input | 1 | Forced value (kinds 1, 4, 5) or blocked target value (kind 2) |
| flt_trig | input | 1 | Aggressor new value that sensitizes (kinds 3, 4) or aggressor level that forces (kind 5) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Access address |
| wdata | input | 1 | Write data |
| rdata | output | 1 | Registered read data |

## Verification
Three behaviours are hard to reach from the ports:

- **Decoder swap.** The swap is invisible while it is active, because reads and writes are remapped alike. The bench writes through the swapped map, turns injection off, and then reads both cells through the true map.
- **Unreachable cell.** The random read value cannot be predicted without copying the LFSR. The bench therefore repeats the read many times, requires both values to appear, and afterwards confirms that the lost write never reached the cell.
- **Coupling sensitization.** To show that coupling depends on a real change of the aggressor, the bench rewrites an unchanged value and checks that the victim stays put.

// File: rtl/fault_ram_pkg.sv
package fault_ram_pkg;
  typedef enum logic [3:0] {
    FK_NONE   = 4'd0,
    FK_STUCK  = 4'd1,
    FK_TRANS  = 4'd2,
    FK_CINV   = 4'd3,
    FK_CIDEM  = 4'd4,
    FK_CSTATE = 4'd5,
    FK_AND    = 4'd6,
    FK_OR     = 4'd7,
    FK_SWAP   = 4'd8,
    FK_LOST   = 4'd9
  } fkind_e;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/fault_ram_decode.sv
module fault_ram_decode
  import fault_ram_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          on,
  input  logic [3:0]    kind,
  input  logic [AW-1:0] victim,
  input  logic [AW-1:0] aggr,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] phys,
  output logic          reach
);
  always_comb begin
    phys  = addr;
    reach = 1'b1;
    if (on) begin
      if (fkind_e'(kind) == FK_SWAP) begin
        if (addr == victim)    phys = aggr;
        else if (addr == aggr) phys = victim;
      end else if (fkind_e'(kind) == FK_LOST) begin
        reach = (addr != victim);
      end
    end
  end
endmodule

// File: rtl/fault_ram_lfsr.sv
module fault_ram_lfsr
  import fault_ram_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] state_d;

  always_comb begin
    state_d = {1'b0, state[LFSR_W-1:1]};
    if (state[0]) state_d = state_d ^ LFSR_TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= state_d;
  end
endmodule

// File: rtl/fault_ram_cells.sv
module fault_ram_cells
  import fault_ram_pkg::*;
#(
  parameter int unsigned AW = 4,
  localparam int unsigned NCELL = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    phys,
  input  logic             reach,
  input  logic             wdata,
  input  logic             on,
  input  logic [3:0]       kind,
  input  logic [AW-1:0]    victim,
  input  logic [AW-1:0]    aggr,
  input  logic             val,
  input  logic             trig,
  output logic [NCELL-1:0] cells
);
  logic [NCELL-1:0] cells_d;
  logic             distinct;
  logic             aggr_sens;
  logic             trans_block;

  assign distinct = (victim != aggr);

  always_comb begin
    cells_d     = cells;
    aggr_sens   = 1'b0;
    trans_block = 1'b0;
    if (wr_en && reach) begin
      trans_block = on && (fkind_e'(kind) == FK_TRANS) && (phys == victim)
                    && (cells[victim] != wdata) && (wdata == val);
      aggr_sens   = on && distinct && (phys == aggr)
                    && (cells[aggr] != wdata) && (wdata == trig);
      if (!trans_block) cells_d[phys] = wdata;
      if (aggr_sens && fkind_e'(kind) == FK_CINV)  cells_d[victim] = ~cells[victim];
      if (aggr_sens && fkind_e'(kind) == FK_CIDEM) cells_d[victim] = val;
    end
    if (on && fkind_e'(kind) == FK_STUCK) cells_d[victim] = val;
    if (on && distinct && fkind_e'(kind) == FK_CSTATE && cells_d[aggr] == trig)
      cells_d[victim] = val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cells <= '0;
    else        cells <= cells_d;
  end
endmodule

// File: rtl/fault_ram.sv
module fault_ram
  import fault_ram_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flt_on,
  input  logic [3:0]    flt_kind,
  input  logic [AW-1:0] flt_victim,
  input  logic [AW-1:0] flt_aggr,
  input  logic          flt_val,
  input  logic          flt_trig,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic          wdata,
  output logic          rdata
);
  localparam int unsigned NCELL = 1 << AW;

  logic [1:0]        rst_sync;
  logic              rst_ln;
  logic [AW-1:0]     phys;
  logic              reach;
  logic [NCELL-1:0]  cells;
  logic [LFSR_W-1:0] lfsr_q;
  logic              rd_val;
  logic              bridged;
  logic              rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ln = rst_sync[1];

  fault_ram_decode #(.AW(AW)) u_dec (
    .on(flt_on), .kind(flt_kind), .victim(flt_victim), .aggr(flt_aggr),
    .addr(addr), .phys(phys), .reach(reach)
  );

  fault_ram_lfsr u_lfsr (.clk(clk), .rst_n(rst_ln), .state(lfsr_q));

  fault_ram_cells #(.AW(AW)) u_cells (
    .clk(clk), .rst_n(rst_ln), .wr_en(wr_en), .phys(phys), .reach(reach),
    .wdata(wdata), .on(flt_on), .kind(flt_kind), .victim(flt_victim),
    .aggr(flt_aggr), .val(flt_val), .trig(flt_trig), .cells(cells)
  );

  assign bridged = flt_on && (phys == flt_victim || phys == flt_aggr);

  always_comb begin
    rd_val = cells[phys];
    if (!reach)
      rd_val = lfsr_q[0];
    else if (bridged && fkind_e'(flt_kind) == FK_AND)
      rd_val = cells[flt_victim] & cells[flt_aggr];
    else if (bridged && fkind_e'(flt_kind) == FK_OR)
      rd_val = cells[flt_victim] | cells[flt_aggr];
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln)    rdata_q <= 1'b0;
    else if (rd_en) rdata_q <= rd_val;
  end
  assign rdata = rdata_q;
endmodule

// File: rtl/fault_ram_chk.sv
module fault_ram_chk
  import fault_ram_pkg::*;
#(
  parameter int unsigned AW = 4,
  localparam int unsigned NCELL = 1 << AW
) (
  input logic              clk,
  input logic              rst_ln,
  input logic              flt_on,
  input logic [3:0]        flt_kind,
  input logic [AW-1:0]     flt_victim,
  input logic [AW-1:0]     flt_aggr,
  input logic              flt_val,
  input logic              flt_trig,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic              wdata,
  input logic              rdata,
  input logic [NCELL-1:0]  cells,
  input logic [LFSR_W-1:0] lfsr_q
);
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_ln)
    !rd_en |=> $stable(rdata));

  p_stuck_read_r3: assert property (@(posedge clk) disable iff (!rst_ln)
    (flt_on && flt_kind == FK_STUCK && rd_en && addr == flt_victim
     && cells[flt_victim] == flt_val) |=> rdata == $past(flt_val));

  p_trans_block_r4: assert property (@(posedge clk) disable iff (!rst_ln)
    (flt_on && flt_kind == FK_TRANS && flt_val && wr_en
     && addr == flt_victim && !cells[flt_victim]) |=> !cells[$past(flt_victim)]);

  p_inv_flip_r5: assert property (@(posedge clk) disable iff (!rst_ln)
    (flt_on && flt_kind == FK_CINV && wr_en && addr == flt_aggr
     && flt_aggr != flt_victim && cells[flt_aggr] != wdata && wdata == flt_trig)
    |=> cells[$past(flt_victim)] != $past(cells[flt_victim]));

  p_state_hold_r7: assert property (@(posedge clk) disable iff (!rst_ln)
    (flt_on && flt_kind == FK_CSTATE && flt_aggr != flt_victim
     && cells[flt_aggr] == flt_trig && !(wr_en && addr == flt_aggr))
    |=> cells[$past(flt_victim)] == $past(flt_val));

  p_bridge_and_r8: assert property (@(posedge clk) disable iff (!rst_ln)
    (flt_on && flt_kind == FK_AND && rd_en && addr == flt_victim
     && flt_victim != flt_aggr)
    |=> rdata == ($past(cells[flt_victim]) & $past(cells[flt_aggr])));

  p_lfsr_live_r10: assert property (@(posedge clk) disable iff (!rst_ln)
    lfsr_q != '0);
endmodule

bind fault_ram fault_ram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_ln(rst_ln), .flt_on(flt_on), .flt_kind(flt_kind),
  .flt_victim(flt_victim), .flt_aggr(flt_aggr), .flt_val(flt_val),
  .flt_trig(flt_trig), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .cells(cells), .lfsr_q(lfsr_q)
);

// File: tb/fault_ram_bench.sv
module fault_ram_bench;
  localparam int AW = 4;
  localparam int NC = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          flt_on;
  logic [3:0]    flt_kind;
  logic [AW-1:0] flt_victim;
  logic [AW-1:0] flt_aggr;
  logic          flt_val;
  logic          flt_trig;
  logic          wr_en;
  logic          rd_en;
  logic [AW-1:0] addr;
  logic          wdata;
  logic          rdata;

  int n_cmp = 0;
  int n_bad = 0;

  fault_ram #(.AW(AW)) u_fault_ram (
    .clk(clk), .rst_n(rst_n), .flt_on(flt_on), .flt_kind(flt_kind),
    .flt_victim(flt_victim), .flt_aggr(flt_aggr), .flt_val(flt_val),
    .flt_trig(flt_trig), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic got, input logic exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic d);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic d);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input int a, input logic exp, input string tag);
    logic d;
    rd(a, d);
    check(d, exp, tag);
  endtask

  task automatic set_fault(input logic on, input int kind, input int v,
                           input int a, input logic val, input logic trig);
    flt_on = on; flt_kind = 4'(kind); flt_victim = AW'(v); flt_aggr = AW'(a);
    flt_val = val; flt_trig = trig;
    @(negedge clk);
  endtask

  task automatic clear_all();
    set_fault(1'b0, 0, 0, 0, 1'b0, 1'b0);
    for (int i = 0; i < NC; i++) wr(i, 1'b0);
  endtask

  task automatic t_reset();
    check(rdata, 1'b0, "R1 rdata after reset");
    for (int i = 0; i < NC; i++) rd_chk(i, 1'b0, "R1 cell after reset");
  endtask

  task automatic t_ideal();
    set_fault(1'b0, 1, 3, 4, 1'b1, 1'b1);
    for (int i = 0; i < NC; i++) wr(i, logic'(i[0] ^ i[2]));
    for (int i = 0; i < NC; i++) rd_chk(i, logic'(i[0] ^ i[2]), "R2 pattern A");
    for (int i = NC - 1; i >= 0; i--) wr(i, logic'(~(i[1] ^ i[3])));
    for (int i = 0; i < NC; i++) rd_chk(i, logic'(~(i[1] ^ i[3])), "R2 pattern B");
  endtask

  task automatic t_hold();
    clear_all();
    wr(5, 1'b1);
    rd_chk(5, 1'b1, "R11 read before hold");
    wr(6, 1'b0); wr(5, 1'b0);
    check(rdata, 1'b1, "R11 rdata held without rd_en");
    @(negedge clk);
    check(rdata, 1'b1, "R11 rdata held idle");
  endtask

  task automatic t_stuck();
    clear_all();
    set_fault(1'b1, 1, 6, 0, 1'b1, 1'b0);
    rd_chk(6, 1'b1, "R3 stuck-at-1 read");
    wr(6, 1'b0);
    rd_chk(6, 1'b1, "R3 stuck-at-1 after write 0");
    wr(7, 1'b1);
    rd_chk(7, 1'b1, "R3 neighbour unaffected");
    set_fault(1'b1, 1, 6, 0, 1'b0, 1'b0);
    wr(6, 1'b1);
    rd_chk(6, 1'b0, "R3 stuck-at-0 after write 1");
  endtask

  task automatic t_trans();
    clear_all();
    set_fault(1'b1, 2, 9, 0, 1'b1, 1'b0);
    wr(9, 1'b1);
    rd_chk(9, 1'b0, "R4 rise blocked");
    set_fault(1'b0, 2, 9, 0, 1'b1, 1'b0);
    wr(9, 1'b1);
    set_fault(1'b1, 2, 9, 0, 1'b1, 1'b0);
    wr(9, 1'b0);
    rd_chk(9, 1'b0, "R4 fall allowed");
    wr(9, 1'b1);
    rd_chk(9, 1'b0, "R4 rise still blocked");
    set_fault(1'b1, 2, 9, 0, 1'b0, 1'b0);
    wr(9, 1'b1);
    rd_chk(9, 1'b1, "R4 rise allowed when fall blocked");
    wr(9, 1'b0);
    rd_chk(9, 1'b1, "R4 fall blocked");
  endtask

  task automatic t_cinv();
    clear_all();
    set_fault(1'b1, 3, 3, 12, 1'b0, 1'b1);
    wr(12, 1'b1);
    rd_chk(3, 1'b1, "R5 rising aggressor flips victim");
    rd_chk(12, 1'b1, "R5 aggressor stored");
    wr(12, 1'b1);
    rd_chk(3, 1'b1, "R5 unchanged aggressor no flip");
    wr(12, 1'b0);
    rd_chk(3, 1'b1, "R5 falling aggressor no flip");
    wr(12, 1'b1);
    rd_chk(3, 1'b0, "R5 second rise flips back");
  endtask

  task automatic t_cidem();
    clear_all();
    set_fault(1'b1, 4, 4, 1, 1'b1, 1'b0);
    wr(1, 1'b1);
    rd_chk(4, 1'b0, "R6 rise does not trigger");
    wr(1, 1'b0);
    rd_chk(4, 1'b1, "R6 fall forces victim");
    wr(4, 1'b0);
    rd_chk(4, 1'b0, "R6 victim writable");
    wr(1, 1'b0);
    rd_chk(4, 1'b0, "R6 unchanged aggressor no force");
  endtask

  task automatic t_cstate();
    clear_all();
    set_fault(1'b1, 5, 10, 11, 1'b0, 1'b1);
    wr(10, 1'b1);
    rd_chk(10, 1'b1, "R7 victim free while aggressor 0");
    wr(11, 1'b1);
    rd_chk(10, 1'b0, "R7 victim forced by aggressor level");
    wr(10, 1'b1);
    rd_chk(10, 1'b0, "R7 write lost while forced");
    wr(11, 1'b0);
    rd_chk(10, 1'b0, "R7 victim keeps value on release");
    wr(10, 1'b1);
    rd_chk(10, 1'b1, "R7 victim writable after release");
  endtask

  task automatic t_bridge();
    clear_all();
    wr(13, 1'b1);
    wr(15, 1'b1);
    set_fault(1'b1, 6, 13, 14, 1'b0, 1'b0);
    rd_chk(13, 1'b0, "R8 AND bridge victim");
    rd_chk(14, 1'b0, "R8 AND bridge aggressor");
    rd_chk(15, 1'b1, "R8 AND bridge other cell");
    set_fault(1'b1, 7, 13, 14, 1'b0, 1'b0);
    rd_chk(13, 1'b1, "R8 OR bridge victim");
    rd_chk(14, 1'b1, "R8 OR bridge aggressor");
    set_fault(1'b0, 0, 0, 0, 1'b0, 1'b0);
    rd_chk(13, 1'b1, "R8 stored victim intact");
    rd_chk(14, 1'b0, "R8 stored aggressor intact");
  endtask

  task automatic t_swap();
    clear_all();
    set_fault(1'b1, 8, 2, 5, 1'b0, 1'b0);
    wr(2, 1'b1);
    rd_chk(2, 1'b1, "R9 swapped read consistent");
    set_fault(1'b0, 0, 0, 0, 1'b0, 1'b0);
    rd_chk(5, 1'b1, "R9 write reached partner cell");
    rd_chk(2, 1'b0, "R9 own cell untouched");
  endtask

  task automatic t_lost();
    logic d;
    logic seen0;
    logic seen1;
    clear_all();
    set_fault(1'b1, 9, 8, 0, 1'b0, 1'b0);
    wr(8, 1'b1);
    seen0 = 1'b0; seen1 = 1'b0;
    for (int i = 0; i < 32; i++) begin
      rd(8, d);
      if (d) seen1 = 1'b1; else seen0 = 1'b1;
    end
    check(seen0 & seen1, 1'b1, "R10 unreachable read varies");
    set_fault(1'b0, 0, 0, 0, 1'b0, 1'b0);
    rd_chk(8, 1'b0, "R10 write to unreachable cell lost");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog all R: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flt_on = 1'b0; flt_kind = 4'd0; flt_victim = '0; flt_aggr = '0;
    flt_val = 1'b0; flt_trig = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ideal();
    t_hold();
    t_stuck();
    t_trans();
    t_cinv();
    t_cidem();
    t_cstate();
    t_bridge();
    t_swap();
    t_lost();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule